// File: doc/BRIEF.md
# Edge and Level Interrupt Detector for a 32-Pin Port

This block watches a port of already-synchronized input pins and turns selected activity on them into interrupt requests. For each pin, software picks a trigger mode: falling edge, rising edge, either edge, high level or low level. The mode is a three-bit code whose bits sit in three separate mode registers, one bit per pin in each. An enable register gates which pins may raise a request.

When an enabled pin matches its mode, the pin's bit in a sticky status register is set. Software clears status bits by writing ones to them. A single registered interrupt line is the OR of all status bits. Edges are found by comparing each new sample with the previous one. The previous sample is primed from the first sample after reset, so reset alone never looks like an edge.

Access is through a plain word-wide register port. A write takes effect on the clock edge where it is presented. Read data appears one clock after the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, enable, all three mode registers and status read as zero, and the interrupt line is low.
- R2: Enable, mode bit 0, mode bit 1 and mode bit 2 are at byte offsets 0x00, 0x04, 0x08 and 0x0C. They read back what was last written to them. A write to one leaves the others unchanged. Offsets other than 0x00 to 0x10 read as zero, and writes to them change nothing. Read data is valid one clock after the address is presented.
- R3: Mode code (bit2, bit1, bit0) = 000 sets the pin's status bit on a 1-to-0 transition.
- R4: Code 001 sets the status bit on a 0-to-1 transition only.
- R5: With bit2 = 1 and bit1 = 0, either transition sets the status bit, whatever bit0 holds.
- R6: With bit1 = 1, the pin is level-sensitive and bit2 is ignored. Bit0 = 1 sets status while the pin is high, and bit0 = 0 sets it while the pin is low.
- R7: A status bit is set only while its enable bit is 1. Clearing an enable bit does not clear a status bit that is already set.
- R8: Status is at offset 0x10. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: For a level-mode pin, a clear wins in the cycle it is written. If the level is still active, the bit sets again on the next clock.
- R10: For an edge-mode pin, an edge detected in the same cycle as a clear of that bit leaves the bit set.
- R11: The interrupt line equals the OR of all status bits, one clock later.
- R12: The first sample after reset is not compared against a reset value, so no edge is reported for pins already held high or low through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, one clock after the address |
| irq_o | output | 1 | Registered OR of all status bits |

## Verification
Two functions can meet in one cycle: a new detection on a pin and a software clear of that same status bit. The bench times a pin transition so that the detection is evaluated in exactly the clock where a write-one-to-clear to that bit lands. It judges the edge case by expecting the bit to stay set, while a neighbouring bit cleared in the same write must drop. For a level pin held active, it reads status in the cycle right after the clear and expects zero, then reads again later and expects the bit to have come back.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFS_ENABLE = 8'h00;
  localparam logic [7:0] OFS_MODE0  = 8'h04;
  localparam logic [7:0] OFS_MODE1  = 8'h08;
  localparam logic [7:0] OFS_MODE2  = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;

  typedef enum logic [2:0] {
    SEL_ENABLE,
    SEL_MODE0,
    SEL_MODE1,
    SEL_MODE2,
    SEL_STATUS,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] status_i,
  output logic [NPINS-1:0] enable_o,
  output logic [NPINS-1:0] mode0_o,
  output logic [NPINS-1:0] mode1_o,
  output logic [NPINS-1:0] mode2_o,
  output logic [NPINS-1:0] clr_o,
  output logic [NPINS-1:0] rdata_o
);
  reg_sel_e sel;
  logic [NPINS-1:0] enable_q, mode0_q, mode1_q, mode2_q, rdata_q;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == AW'(OFS_ENABLE))      sel = SEL_ENABLE;
    else if (addr_i == AW'(OFS_MODE0))  sel = SEL_MODE0;
    else if (addr_i == AW'(OFS_MODE1))  sel = SEL_MODE1;
    else if (addr_i == AW'(OFS_MODE2))  sel = SEL_MODE2;
    else if (addr_i == AW'(OFS_STATUS)) sel = SEL_STATUS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      mode0_q  <= '0;
      mode1_q  <= '0;
      mode2_q  <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_ENABLE: enable_q <= wdata_i;
        SEL_MODE0:  mode0_q  <= wdata_i;
        SEL_MODE1:  mode1_q  <= wdata_i;
        SEL_MODE2:  mode2_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (sel)
        SEL_ENABLE: rdata_q <= enable_q;
        SEL_MODE0:  rdata_q <= mode0_q;
        SEL_MODE1:  rdata_q <= mode1_q;
        SEL_MODE2:  rdata_q <= mode2_q;
        SEL_STATUS: rdata_q <= status_i;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign clr_o    = (wr_i && sel == SEL_STATUS) ? wdata_i : '0;
  assign enable_o = enable_q;
  assign mode0_o  = mode0_q;
  assign mode1_o  = mode1_q;
  assign mode2_o  = mode2_q;
  assign rdata_o  = rdata_q;

  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_i && sel == SEL_ENABLE) |-> $stable(enable_q));
  // R2
  mode1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_i && sel == SEL_MODE1) |-> $stable(mode1_q));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] mode0_i,
  input  logic [NPINS-1:0] mode1_i,
  input  logic [NPINS-1:0] mode2_i,
  output logic [NPINS-1:0] event_o,
  output logic [NPINS-1:0] level_o
);
  logic [NPINS-1:0] cur_q, prev_q;
  logic             primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      cur_q    <= pins_i;
      prev_q   <= primed_q ? cur_q : pins_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic rise, fall, hit;
    always_comb begin
      rise = cur_q[p] & ~prev_q[p];
      fall = ~cur_q[p] & prev_q[p];
      if (mode1_i[p])      hit = mode0_i[p] ? cur_q[p] : ~cur_q[p];
      else if (mode2_i[p]) hit = rise | fall;
      else if (mode0_i[p]) hit = rise;
      else                 hit = fall;
    end
    assign event_o[p] = primed_q & hit;
    assign level_o[p] = mode1_i[p];
  end

  // R12
  first_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(primed_q) |-> ((event_o & ~level_o) == '0));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] enable_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);
  logic [NPINS-1:0] st_q, set_v;
  logic             irq_q;

  assign set_v = event_i & enable_i & ~(clr_i & level_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= (st_q & ~clr_i) | set_v;
      irq_q <= |st_q;
    end
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;

  // R8
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (($past(st_q) & ~$past(clr_i) & ~st_q) == '0));
  // R7
  set_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((st_q & ~$past(st_q) & ~$past(enable_i)) == '0));
  // R9
  level_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (($past(clr_i & level_i) & st_q) == '0));
  // R10
  edge_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (($past(clr_i & event_i & enable_i & ~level_i) & ~st_q) == '0));
  // R11
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == '0) |=> !irq_q);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_o
);
  logic [NPINS-1:0] enable, mode0, mode1, mode2, clr, status, events, level;

  gpio_irq_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .status_i(status), .enable_o(enable), .mode0_o(mode0), .mode1_o(mode1),
    .mode2_o(mode2), .clr_o(clr), .rdata_o(bus_rdata)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .pins_i(pins_i), .mode0_i(mode0), .mode1_i(mode1),
    .mode2_i(mode2), .event_o(events), .level_o(level)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst(rst), .event_i(events), .level_i(level), .enable_i(enable),
    .clr_i(clr), .status_o(status), .irq_o(irq_o)
  );

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(status) != '0));
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  localparam int NP = 32;
  localparam logic [7:0] A_EN = 8'h00, A_M0 = 8'h04, A_M1 = 8'h08,
                         A_M2 = 8'h0C, A_ST = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic irq_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gpio_irq_bank uut (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [NP-1:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [NP-1:0] exp_after(input logic [2:0] c, input logic [NP-1:0] p0,
                                              input logic [NP-1:0] p1);
    if (c[1])      return c[0] ? (p0 | p1) : (~p0 | ~p1);
    else if (c[2]) return p0 ^ p1;
    else if (c[0]) return ~p0 & p1;
    else           return p0 & ~p1;
  endfunction

  logic [NP-1:0] d, e;
  logic [NP-1:0] pa [4];
  logic [NP-1:0] pb [4];

  initial begin
    pa[0] = 32'h0000FFFF; pb[0] = 32'h00FF00FF;
    pa[1] = 32'hAAAAAAAA; pb[1] = 32'h55555555;
    pa[2] = 32'h12345678; pb[2] = 32'hFEDCBA98;
    pa[3] = 32'hFFFFFFFF; pb[3] = 32'h00000000;

    // R12: pins held high through reset, rising mode enabled at once
    pins = '1;
    idle(3);
    rst = 1'b0;
    wr(A_M0, '1);
    wr(A_EN, '1);
    idle(3);
    rd(A_ST, d); chk("R12 no edge from reset", d, '0);
    rst = 1'b1; idle(2); rst = 1'b0; pins = '0; idle(2);

    // R1 reset values
    rd(A_EN, d); chk("R1 enable", d, '0);
    rd(A_M0, d); chk("R1 mode0", d, '0);
    rd(A_M1, d); chk("R1 mode1", d, '0);
    rd(A_M2, d); chk("R1 mode2", d, '0);
    rd(A_ST, d); chk("R1 status", d, '0);
    chk("R1 irq", NP'(irq_o), '0);

    // R2 readback and isolation
    wr(A_M0, 32'h11111111); wr(A_M1, 32'h22222222); wr(A_M2, 32'h44444444);
    wr(A_EN, 32'h0);
    wr(8'h14, 32'hFFFFFFFF);
    rd(A_M0, d); chk("R2 mode0", d, 32'h11111111);
    rd(A_M1, d); chk("R2 mode1", d, 32'h22222222);
    rd(A_M2, d); chk("R2 mode2", d, 32'h44444444);
    rd(A_EN, d); chk("R2 enable untouched", d, 32'h0);
    rd(8'h14, d); chk("R2 unmapped reads zero", d, '0);
    wr(A_EN, 32'h00000081); wr(A_EN, 32'h00000080);
    rd(A_EN, d); chk("R2 enable single bit", d, 32'h00000080);

    // R3 R4 R5 R6 R8 R11 sweep over all codes and pin patterns
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [2:0] cc;
        cc = 3'(c);
        wr(A_EN, '0);
        wr(A_M0, {NP{cc[0]}}); wr(A_M1, {NP{cc[1]}}); wr(A_M2, {NP{cc[2]}});
        pins = pa[k];
        idle(3);
        wr(A_ST, '1);
        wr(A_EN, '1);
        idle(3);
        e = cc[1] ? (cc[0] ? pa[k] : ~pa[k]) : '0;
        rd(A_ST, d); chk($sformatf("R6 R8 steady code%0d", c), d, e);
        wr(A_ST, '1);
        pins = pb[k];
        idle(3);
        e = exp_after(cc, pa[k], pb[k]);
        rd(A_ST, d); chk($sformatf("R3 R4 R5 R6 code%0d pair%0d", c, k), d, e);
        chk($sformatf("R11 irq code%0d", c), NP'(irq_o), NP'(e != '0));
      end
    end

    // R7 enable gating and retention; R8 write-zero keeps
    wr(A_EN, '0); wr(A_M0, '1); wr(A_M1, '0); wr(A_M2, '0);
    pins = '0; idle(3); wr(A_ST, '1);
    wr(A_EN, 32'h0000000F);
    pins = 32'h000000FF; idle(3);
    rd(A_ST, d); chk("R7 only enabled pins", d, 32'h0000000F);
    wr(A_EN, '0);
    wr(A_ST, 32'h0);
    rd(A_ST, d); chk("R7 R8 kept after disable and zero write", d, 32'h0000000F);
    pins = '0; idle(2); pins = 32'h000000FF; idle(3);
    wr(A_ST, 32'h00000003);
    rd(A_ST, d); chk("R8 partial clear", d, 32'h0000000C);

    // R10 edge in the clear cycle
    wr(A_ST, '1); pins = '0;
    wr(A_EN, 32'h00000018); idle(2);
    pins = 32'h00000010; idle(3);
    pins = 32'h00000000; idle(2);
    rd(A_ST, d); chk("R10 setup", d, 32'h00000010);
    pins = 32'h00000008;
    @(negedge clk);
    wr(A_ST, 32'h00000018);
    idle(1);
    rd(A_ST, d); chk("R10 edge wins over clear", d, 32'h00000008);

    // R9 level re-assert
    wr(A_EN, '0); wr(A_ST, '1);
    wr(A_M1, 32'h00000020); wr(A_M0, 32'h00000020);
    pins = 32'h00000020; wr(A_EN, 32'h00000020); idle(3);
    wr(A_ST, 32'h00000020);
    rd(A_ST, d); chk("R9 cleared in clear cycle", d, 32'h0);
    idle(1);
    rd(A_ST, d); chk("R9 re-asserted", d, 32'h00000020);

    // R11 irq latency
    wr(A_EN, '0); wr(A_M1, '0); wr(A_M0, '1); pins = '0; idle(2);
    wr(A_ST, '1); wr(A_EN, 32'h1); idle(3);
    chk("R11 idle irq", NP'(irq_o), '0);
    pins = 32'h1;
    @(negedge clk); chk("R11 irq after sample", NP'(irq_o), '0);
    @(negedge clk); chk("R11 irq same cycle as status", NP'(irq_o), '0);
    @(negedge clk); chk("R11 irq one cycle after status", NP'(irq_o), 32'h1);
    wr(A_ST, 32'h1);
    chk("R11 irq holds one cycle after clear", NP'(irq_o), 32'h1);
    @(negedge clk); chk("R11 irq drops", NP'(irq_o), '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule